// File: doc/BRIEF.md
# Real-Time Clock Counter With Coherent Read Snapshot

This block keeps time of day and calendar position in seven plain binary counters: hundredths, seconds, minutes, hours, weekday, day of month and month. A single-cycle 100 Hz tick input advances the chain while the run bit of an 8-bit command register is set. Software stops the clock, loads the fields over an active-low chip-select/read/write bus, and restarts it.

Reading the hundredths field copies every counter into a 36-bit snapshot in the first cycle of the read. Reads of the other fields then return snapshot values, so a multi-byte read of the time is coherent even across a tick. A tick that arrives while a read is active is held and applied when the read ends. Only one such tick is held, so extra ticks during an over-long read are lost. A power-fail input blocks the bus, so reads drive nothing and writes are dropped. Month lengths and leap years are not modelled: every month is treated as 31 days.

Top module: `rtc_snapshot_clock`

## Requirements
- R1: Command register (address 7, 8 bits, reads back as written) bit 3 is the run bit: with it 1 each applied tick advances the counters, with it 0 ticks have no effect.
- R2: The first cycle of a read of address 0 (hundredths) stores all seven live fields into the snapshot, and that read returns the captured hundredths value.
- R3: Reads of addresses 1 to 6 (seconds, minutes, hours, weekday, date, month) return snapshot values, unchanged until the next hundredths read.
- R4: A tick that arrives while a read is active (cs_n and rd_n low, pwr_fail low) leaves the counters unchanged during the read and is applied once the read ends.
- R5: At most one deferred tick is held: several ticks during one read advance the time by exactly one hundredth.
- R6: rdata_en is high only while cs_n and rd_n are low and pwr_fail is low, and rdata is zero whenever rdata_en is low. With cs_n and wr_n low, wdata is loaded into the field at addr (0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 command), taking the low bits the field holds.
- R7: While pwr_fail is high, rdata_en stays low and writes change nothing.
- R8: Hundredths wrap from 99 to 0 and carry into seconds. Seconds and minutes wrap from 59 to 0 and carry on. Hours wrap from 23 to 0.
- R9: An hours wrap advances both weekday (6 wraps to 0) and date (31 wraps to 1). A date wrap advances month (12 wraps to 1).
- R10: A write to a time field in the same cycle as an applied tick wins: the field takes the written value and that tick's increment is discarded.
- R11: After reset, hundredths through weekday are 0, date and month are 1, the command register is 0, and the snapshot holds those same values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle pulse at each 10 ms step |
| pwr_fail | input | 1 | Supply failing, locks out the bus |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_en | output | 1 | Bus driver enable for rdata |

## Verification
The bench builds the block with its default widths: a 3-bit address, an 8-bit data path and the fixed 36-bit field layout. Because every field can be loaded directly, a short run of ticks from a preset such as 23:59:59.98 on the 31st of month 12 reaches every wrap, including the double carry from hours into weekday and date, without hours of simulated time. Held read strobes make the deferral, single-tick-limit and snapshot-hold cases reachable in a few cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int RTC_DW     = 8;
  localparam int RTC_AW     = 3;
  localparam int NUM_FIELDS = 7;
  localparam int FLD_MAXW   = 7;
  localparam int CMD_ADDR   = 7;

  // field order: hundredths, seconds, minutes, hours, weekday, date, month
  function automatic int fld_w(input int i);
    case (i)
      0: return 7;
      1: return 6;
      2: return 6;
      3: return 5;
      4: return 3;
      5: return 5;
      default: return 4;
    endcase
  endfunction

  function automatic int fld_lsb(input int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += fld_w(k);
    return s;
  endfunction

  localparam int TIME_W = fld_lsb(NUM_FIELDS);

  function automatic int fld_min(input int i);
    return (i == 5 || i == 6) ? 1 : 0;
  endfunction

  function automatic int fld_max(input int i);
    case (i)
      0: return 99;
      1: return 59;
      2: return 59;
      3: return 23;
      4: return 6;
      5: return 31;
      default: return 12;
    endcase
  endfunction

  // index of the field whose wrap steps field i, -1 for the tick itself
  function automatic int carry_src(input int i);
    case (i)
      0: return -1;
      4: return 3;
      5: return 3;
      default: return i - 1;
    endcase
  endfunction

  // per-field step enables from the base increment and the at-max flags
  function automatic logic [NUM_FIELDS-1:0] step_mask(input logic inc,
                                                      input logic [NUM_FIELDS-1:0] at_max);
    logic [NUM_FIELDS-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (carry_src(i) < 0) s[i] = inc;
      else                  s[i] = s[carry_src(i)] & at_max[carry_src(i)];
    end
    return s;
  endfunction

  function automatic logic [RTC_DW-1:0] get_field(input logic [TIME_W-1:0] v, input int i);
    logic [RTC_DW-1:0] r;
    r = '0;
    for (int b = 0; b < RTC_DW; b++)
      if (b < fld_w(i)) r[b] = v[fld_lsb(i) + b];
    return r;
  endfunction

  function automatic logic [TIME_W-1:0] reset_time();
    logic [TIME_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      for (int b = 0; b < fld_w(i); b++)
        r[fld_lsb(i) + b] = fld_min(i)[b];
    return r;
  endfunction

endpackage

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
  parameter int W    = 7,
  parameter int MINV = 0,
  parameter int MAXV = 99
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         at_max
);

  logic [W-1:0] q;

  // out-of-range loaded values also wrap on the next step
  assign at_max = (q >= W'(MAXV));
  assign val    = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= W'(MINV);
    else if (load)  q <= ld_val;
    else if (step)  q <= at_max ? W'(MINV) : W'(q + 1'b1);
  end

endmodule

// File: rtl/rtc_bus_ctl.sv
module rtc_bus_ctl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              pwr_fail,
  input  logic [RTC_AW-1:0] addr,
  output logic              rd_act,
  output logic              wr_act,
  output logic              wr_time,
  output logic              store_pulse
);

  logic rd_act_q;

  assign rd_act  = !cs_n && !rd_n && !pwr_fail;              // R6 R7
  assign wr_act  = !cs_n && !wr_n && !pwr_fail;
  assign wr_time = wr_act && (int'(addr) < NUM_FIELDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_act_q <= 1'b0;
    else        rd_act_q <= rd_act;
  end

  // capture at the first cycle of a hundredths read (R2)
  assign store_pulse = rd_act && !rd_act_q && (addr == '0);

endmodule

// File: rtl/rtc_tick_defer.sv
module rtc_tick_defer (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic rd_act,
  output logic apply,
  output logic pending
);

  logic tick_run;

  assign tick_run = tick && run;
  assign apply    = !rd_act && (tick_run || pending);        // R4

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (rd_act) pending <= pending || tick_run;         // R5: one slot only
    else             pending <= pending && tick_run;
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                wr_en,
  input  logic [RTC_AW-1:0]   wr_sel,
  input  logic [FLD_MAXW-1:0] wr_val,
  output logic [TIME_W-1:0]   live
);

  logic [NUM_FIELDS-1:0] at_max;
  logic [NUM_FIELDS-1:0] step;

  assign step = step_mask(inc, at_max);                      // R8 R9

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int W   = fld_w(g);
    localparam int LSB = fld_lsb(g);
    logic [W-1:0] v;
    logic         ld;

    assign ld = wr_en && (int'(wr_sel) == g);

    rtc_field_ctr #(
      .W    (W),
      .MINV (fld_min(g)),
      .MAXV (fld_max(g))
    ) i_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step[g]),
      .load   (ld),
      .ld_val (wr_val[W-1:0]),
      .val    (v),
      .at_max (at_max[g])
    );

    assign live[LSB +: W] = v;
  end

endmodule

// File: rtl/rtc_snap_read.sv
module rtc_snap_read
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store,
  input  logic              rd_act,
  input  logic [RTC_AW-1:0] addr,
  input  logic [TIME_W-1:0] live,
  input  logic [RTC_DW-1:0] cmd,
  output logic [TIME_W-1:0] snap,
  output logic [RTC_DW-1:0] rdata,
  output logic              rdata_en
);

  logic [RTC_DW-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap <= reset_time();
    else if (store) snap <= live;                            // R2
  end

  always_comb begin
    if (int'(addr) == CMD_ADDR)  sel = cmd;
    else if (store)              sel = get_field(live, 0);   // same value the snapshot takes
    else                         sel = get_field(snap, int'(addr)); // R3
  end

  assign rdata_en = rd_act;
  assign rdata    = rd_act ? sel : '0;                       // R6

endmodule

// File: rtl/rtc_snapshot_clock.sv
module rtc_snapshot_clock
  import rtc_pkg::*;
#(
  parameter int RUN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              pwr_fail,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [RTC_AW-1:0] addr,
  input  logic [RTC_DW-1:0] wdata,
  output logic [RTC_DW-1:0] rdata,
  output logic              rdata_en
);

  logic              rd_act, wr_act, wr_time, store_pulse;
  logic              apply, pending, inc_en, run;
  logic [RTC_DW-1:0] cmd_q;
  logic [TIME_W-1:0] live_time, snap_time;

  rtc_bus_ctl i_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .pwr_fail    (pwr_fail),
    .addr        (addr),
    .rd_act      (rd_act),
    .wr_act      (wr_act),
    .wr_time     (wr_time),
    .store_pulse (store_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      cmd_q <= '0;   // R11
    else if (wr_act && int'(addr) == CMD_ADDR)       cmd_q <= wdata;
  end

  assign run = cmd_q[RUN_BIT];                               // R1

  rtc_tick_defer i_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_100hz),
    .run     (run),
    .rd_act  (rd_act),
    .apply   (apply),
    .pending (pending)
  );

  // a time-field write discards the increment of the same cycle (R10)
  assign inc_en = apply && run && !wr_time;

  rtc_time_chain i_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (inc_en),
    .wr_en  (wr_time),
    .wr_sel (addr),
    .wr_val (wdata[FLD_MAXW-1:0]),
    .live   (live_time)
  );

  rtc_snap_read i_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .store    (store_pulse),
    .rd_act   (rd_act),
    .addr     (addr),
    .live     (live_time),
    .cmd      (cmd_q),
    .snap     (snap_time),
    .rdata    (rdata),
    .rdata_en (rdata_en)
  );

endmodule

// File: rtl/rtc_snapshot_clock_chk.sv
module rtc_snapshot_clock_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_fail,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [RTC_AW-1:0] addr,
  input logic [RTC_DW-1:0] wdata,
  input logic [RTC_DW-1:0] rdata,
  input logic              rdata_en,
  input logic              rd_act,
  input logic              wr_act,
  input logic              store_pulse,
  input logic              pending,
  input logic              run,
  input logic [TIME_W-1:0] live_time,
  input logic [TIME_W-1:0] snap_time
);

  localparam int HW = fld_w(0);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_act) |=> $stable(live_time)); // R1

  AST_SNAP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> (snap_time == $past(live_time))); // R2

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !store_pulse |=> $stable(snap_time)); // R3

  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !wr_act) |=> $stable(live_time)); // R4

  AST_DEFER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !rd_act && run && !wr_act) |=> (live_time[HW-1:0] != $past(live_time[HW-1:0]))); // R4

  AST_RDEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |-> (!cs_n && !rd_n)); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> (rdata == '0)); // R6

  AST_PWRFAIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!rdata_en && !wr_act)); // R7

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> (!cs_n && !wr_n)); // R6

  AST_HUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> ((live_time[HW-1:0] == $past(live_time[HW-1:0])) ||
                 (live_time[HW-1:0] == (($past(live_time[HW-1:0]) >= HW'(99)) ? '0
                                         : $past(live_time[HW-1:0]) + 1'b1)))); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && addr == '0) |=> (live_time[HW-1:0] == $past(wdata[HW-1:0]))); // R10

endmodule

bind rtc_snapshot_clock rtc_snapshot_clock_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_fail    (pwr_fail),
  .cs_n        (cs_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .rdata_en    (rdata_en),
  .rd_act      (rd_act),
  .wr_act      (wr_act),
  .store_pulse (store_pulse),
  .pending     (pending),
  .run         (run),
  .live_time   (live_time),
  .snap_time   (snap_time)
);

// File: tb/test_rtc_snapshot_clock.sv
module test_rtc_snapshot_clock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_snapshot_clock i_rtc_snapshot_clock (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .pwr_fail(pwr_fail),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  // start and expected fields listed {month, date, weekday, hours, minutes, seconds, hundredths}
  typedef struct packed {
    logic [6:0][7:0] st;
    logic [7:0]      n;
    logic [6:0][7:0] ex;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{st: {8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},      n: 8'd5,
      ex: {8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5}},
    '{st: {8'd12, 8'd31, 8'd6, 8'd23, 8'd59, 8'd59, 8'd98}, n: 8'd3,
      ex: {8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1}},
    '{st: {8'd6, 8'd14, 8'd2, 8'd5, 8'd10, 8'd58, 8'd99},   n: 8'd1,
      ex: {8'd6, 8'd14, 8'd2, 8'd5, 8'd10, 8'd59, 8'd0}},
    '{st: {8'd4, 8'd9, 8'd3, 8'd22, 8'd59, 8'd59, 8'd99},   n: 8'd2,
      ex: {8'd4, 8'd9, 8'd3, 8'd23, 8'd0, 8'd0, 8'd1}},
    '{st: {8'd2, 8'd30, 8'd1, 8'd23, 8'd59, 8'd59, 8'd50},  n: 8'd50,
      ex: {8'd2, 8'd31, 8'd2, 8'd0, 8'd0, 8'd0, 8'd0}},
    '{st: {8'd7, 8'd15, 8'd5, 8'd23, 8'd59, 8'd59, 8'd99},  n: 8'd1,
      ex: {8'd7, 8'd16, 8'd6, 8'd0, 8'd0, 8'd0, 8'd0}}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input int a, output int d, output int en);
    @(negedge clk);
    addr = 3'(a); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = int'(rdata); en = int'(rdata_en);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_100hz = 1'b1;
    @(negedge clk); tick_100hz = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int d, en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R11 idle rdata_en", int'(rdata_en), 0);
    bus_read(5, d, en); chk("R11 date snapshot", d, 1);
    bus_read(6, d, en); chk("R11 month snapshot", d, 1);
    bus_read(7, d, en); chk("R11 command", d, 0);
    bus_read(0, d, en); chk("R11 hundredths", d, 0);
    chk("R6 rdata_en during read", en, 1);

    // vector table: load, run, tick, stop, capture, read back
    for (int v = 0; v < 6; v++) begin
      bus_write(7, 0);
      for (int f = 0; f < 7; f++) bus_write(f, int'(VECS[v].st[f]));
      bus_write(7, 8'h08);
      for (int t = 0; t < int'(VECS[v].n); t++) pulse_tick();
      bus_write(7, 0);
      for (int f = 0; f < 7; f++) begin
        bus_read(f, d, en);
        chk($sformatf("R8 R9 vector %0d field %0d", v, f), d, int'(VECS[v].ex[f]));
      end
    end

    // R1: stopped clock ignores ticks; command reads back all bits
    bus_write(7, 8'hA5);
    bus_read(7, d, en); chk("R1 command readback", d, 8'hA5);
    bus_write(7, 0);
    bus_write(0, 30);
    repeat (4) pulse_tick();
    bus_read(0, d, en); chk("R1 stopped hundredths", d, 30);

    // R2/R3: snapshot holds across a tick until the next hundredths read
    bus_write(0, 99); bus_write(1, 10);
    bus_write(7, 8'h08);
    bus_read(0, d, en); chk("R2 captured hundredths", d, 99);
    pulse_tick();
    bus_read(1, d, en); chk("R3 seconds held in snapshot", d, 10);
    bus_read(0, d, en); chk("R2 new capture hundredths", d, 0);
    bus_read(1, d, en); chk("R2 new capture seconds", d, 11);

    // R4: tick during a held hundredths read is deferred
    bus_write(0, 10);
    @(negedge clk); addr = 3'd0; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); tick_100hz = 1'b1;
    @(negedge clk); tick_100hz = 1'b0;
    @(negedge clk);
    chk("R4 value during read", int'(rdata), 10);
    chk("R6 rdata_en held read", int'(rdata_en), 1);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(0, d, en); chk("R4 deferred tick applied", d, 11);

    // R5: three ticks during one read advance by one
    @(negedge clk); addr = 3'd1; cs_n = 1'b0; rd_n = 1'b0;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(0, d, en); chk("R5 single deferred tick", d, 12);

    // R10: write and tick in the same cycle
    @(negedge clk);
    addr = 3'd0; wdata = 8'd40; cs_n = 1'b0; wr_n = 1'b0; tick_100hz = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; tick_100hz = 1'b0;
    bus_write(7, 0);
    bus_read(0, d, en); chk("R10 write wins over tick", d, 40);

    // R6: read strobe without chip select
    @(negedge clk); addr = 3'd0; rd_n = 1'b0;
    @(negedge clk);
    chk("R6 no cs rdata_en", int'(rdata_en), 0);
    chk("R6 no cs rdata", int'(rdata), 0);
    rd_n = 1'b1;

    // R7: power fail blocks reads and writes
    @(negedge clk); pwr_fail = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R7 read blocked", int'(rdata_en), 0);
    cs_n = 1'b1; rd_n = 1'b1;
    bus_write(0, 77);
    @(negedge clk); pwr_fail = 1'b0;
    bus_read(0, d, en); chk("R7 write ignored", d, 40);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule